// File: doc/BRIEF.md
# Linked-List DMA Descriptor Fetcher

This block walks a chain of command nodes held in memory and feeds each one to a data mover. Software writes the address of the first node into the list-pointer register of the channel window, then starts the chain through the control word. For every node the fetcher issues eight single-word reads on a request/response port. It captures the words as the channel's working configuration, starts the mover, and waits for the mover's done pulse. It then moves on to the node named by the link word.

A link of zero ends the chain. A link that points back to an earlier node makes the chain circular, and that chain runs until software cancels it. Two event pulses report progress. One marks that the first node of a chain is loaded. The other marks each finished command. A cancel may arrive while a read is still outstanding. The fetcher then drops that late response and issues no new read until the response has come back.

Top module: `llist_fetch`

## Requirements
- R1: After reset the block is idle: `busy_o`, `rd_req_o`, `mv_start_o`, `mv_abort_o`, `list_loaded_o` and `cmd_done_o` are all low.
- R2: A register write at window offset 0x1C with bit 0 (enable) and bit 4 (list enable) both set, and bit 20 clear, starts a fetch from the list-pointer register at offset 0x14. The following have no effect: a control write with only one of bits 0 and 4 set, and any start write while busy.
- R3: A node is read as eight word requests, one outstanding at a time, at node address + 4*i for i = 0..7. Address bits [1:0] of the list pointer and of every link are treated as zero. A request holds its address until it is granted.
- R4: The captured words map as follows. Word 0 drives `cfg_gen_o`, word 1 drives `cfg_port_o`, word 2 drives `cfg_src_o`, word 3 drives `cfg_dst_o`, and bits [23:0] of word 4 (byte count minus one) drive `cfg_len_o`. Word 5 is the link and word 6 is the command-done word. Bit 0 of word 7 is the run enable.
- R5: `list_loaded_o` pulses for one cycle once per chain, in the cycle after the eighth word of the first node is captured.
- R6: `mv_start_o` pulses in the cycle after a node's eighth word is captured, if that node's run enable is set. A node whose run enable is clear gives no start and no completion, and its link is followed at once.
- R7: `cmd_done_o` pulses in the cycle `mv_done_i` arrives while a command runs. If the link is zero the block then goes idle; otherwise it requests the next node in the following cycle.
- R8: A circular chain keeps repeating and gives one completion per node until it is cancelled.
- R9: A control write with bit 20 set returns the block to idle in the next cycle from any state. The cancel wins over bit 4 and over a `mv_done_i` in the same cycle, and it pulses `mv_abort_o` when a command is running.
- R10: If a cancel lands while a read is outstanding, the response to that read is discarded. No new read is issued until that response has arrived.
- R11: `busy_o` is high from the cycle after a start until the block returns to idle.
- R12: `mv_done_i` while idle or while fetching has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Byte offset inside the channel window |
| reg_wdata_i | input | 32 | Register write data |
| rd_req_o | output | 1 | Word read request |
| rd_addr_o | output | 32 | Word read address |
| rd_gnt_i | input | 1 | Read request accepted |
| rd_rvalid_i | input | 1 | Read response valid |
| rd_rdata_i | input | 32 | Read response data |
| mv_start_o | output | 1 | Start pulse to the data mover |
| mv_abort_o | output | 1 | Abort pulse to the data mover |
| mv_done_i | input | 1 | Data mover completion pulse |
| cfg_gen_o | output | 32 | General configuration word of the current node |
| cfg_port_o | output | 32 | Read-port configuration word |
| cfg_src_o | output | 32 | Read address |
| cfg_dst_o | output | 32 | Write address |
| cfg_len_o | output | 24 | Byte count minus one |
| list_loaded_o | output | 1 | First node of the chain loaded |
| cmd_done_o | output | 1 | One command finished |
| busy_o | output | 1 | Chain in progress |

## Verification
Five patterns drive the chain walk.
- A single node with an always-ready port and one-cycle reads shows the basic word order and field mapping.
- A three-node chain has a grant that drops every other cycle and a longer read latency. Its middle node is disabled and its link is unaligned. This pattern separates request holding, link alignment and node skipping.
- A two-node circular chain, cancelled while a command runs, tests repetition and abort.
- A cancel made while a read is in flight, followed at once by a new start, tests whether stale data leaks into the next chain.
- Stray done pulses, sent while idle and while fetching, test that done is only taken while a command runs.

// File: rtl/llist_pkg.sv
package llist_pkg;
  localparam int NODE_WORDS = 8;
  localparam int IDX_W      = $clog2(NODE_WORDS);

  localparam int W_GEN   = 0;
  localparam int W_PORT  = 1;
  localparam int W_SRC   = 2;
  localparam int W_DST   = 3;
  localparam int W_LEN   = 4;
  localparam int W_LINK  = 5;
  localparam int W_CDONE = 6;
  localparam int W_CTRL  = 7;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_WAIT,
    S_DISP,
    S_RUN
  } seq_state_e;
endpackage

// File: rtl/llist_ctrl_regs.sv
module llist_ctrl_regs #(
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          WIN_AW   = 6,
  parameter int          ALIGN    = 2,
  parameter logic [5:0]  OFS_LIST = 6'h14,
  parameter logic [5:0]  OFS_CTRL = 6'h1C,
  parameter int          BIT_EN   = 0,
  parameter int          BIT_LEN  = 4,
  parameter int          BIT_CAN  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WIN_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [AW-1:0]     list_addr_o,
  output logic              start_o,
  output logic              cancel_o
);
  logic [AW-1:ALIGN] list_q;
  logic hit_list, hit_ctrl;

  assign hit_list = we_i && (addr_i == WIN_AW'(OFS_LIST));
  assign hit_ctrl = we_i && (addr_i == WIN_AW'(OFS_CTRL));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       list_q <= '0;
    else if (hit_list) list_q <= wdata_i[AW-1:ALIGN];
  end

  assign list_addr_o = {list_q, {ALIGN{1'b0}}};
  assign cancel_o    = hit_ctrl && wdata_i[BIT_CAN];
  // cancel outranks list enable in the same write
  assign start_o     = hit_ctrl && wdata_i[BIT_LEN] && wdata_i[BIT_EN] && !wdata_i[BIT_CAN];

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[ALIGN-1:0]};
endmodule

// File: rtl/llist_node_buf.sv
module llist_node_buf
  import llist_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cap_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [DW-1:0]                    data_i,
  output logic [NODE_WORDS-1:0][DW-1:0]    words_o
);
  for (genvar g = 0; g < NODE_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 words_o[g] <= '0;
      else if (cap_i && idx_i == IDX_W'(g))        words_o[g] <= data_i;
    end
  end
endmodule

// File: rtl/llist_seq.sv
module llist_seq
  import llist_pkg::*;
#(
  parameter int AW    = 32,
  parameter int ALIGN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cancel_i,
  input  logic [AW-1:0]    list_addr_i,
  input  logic [AW-1:0]    link_i,
  input  logic             run_en_i,
  input  logic             rd_gnt_i,
  input  logic             rd_rvalid_i,
  input  logic             mv_done_i,
  output logic             rd_req_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic             cap_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             mv_start_o,
  output logic             mv_abort_o,
  output logic             list_loaded_o,
  output logic             cmd_done_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NODE_WORDS - 1);

  seq_state_e       st_q, st_d;
  logic [AW-1:0]    node_q, node_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             first_q, first_d;
  logic             stale_q, stale_d;
  logic [AW-1:0]    link_al;
  logic             link_end, issue;

  assign link_al  = {link_i[AW-1:ALIGN], {ALIGN{1'b0}}};
  assign link_end = (link_al == '0);

  assign rd_req_o      = (st_q == S_REQ) && !stale_q;
  assign rd_addr_o     = node_q + ({{(AW-IDX_W){1'b0}}, idx_q} << ALIGN);
  assign issue         = rd_req_o && rd_gnt_i;
  assign cap_o         = (st_q == S_WAIT) && rd_rvalid_i && !cancel_i;
  assign idx_o         = idx_q;
  assign busy_o        = (st_q != S_IDLE);
  assign list_loaded_o = (st_q == S_DISP) && first_q && !cancel_i;
  assign mv_start_o    = (st_q == S_DISP) && run_en_i && !cancel_i;
  assign cmd_done_o    = (st_q == S_RUN) && mv_done_i && !cancel_i;
  assign mv_abort_o    = (st_q == S_RUN) && cancel_i;

  always_comb begin
    st_d    = st_q;
    node_d  = node_q;
    idx_d   = idx_q;
    first_d = first_q;
    // a read still in flight at cancel leaves one response to swallow
    stale_d = stale_q && !rd_rvalid_i;
    if (cancel_i)
      stale_d = stale_d || ((st_q == S_WAIT) && !rd_rvalid_i) || issue;

    unique case (st_q)
      S_IDLE: if (start_i) begin
        st_d    = S_REQ;
        node_d  = list_addr_i;
        idx_d   = '0;
        first_d = 1'b1;
      end
      S_REQ: if (issue) st_d = S_WAIT;
      S_WAIT: if (rd_rvalid_i) begin
        if (idx_q == LAST_IDX) st_d = S_DISP;
        else begin
          idx_d = idx_q + 1'b1;
          st_d  = S_REQ;
        end
      end
      S_DISP: begin
        first_d = 1'b0;
        if (run_en_i)      st_d = S_RUN;
        else if (link_end) st_d = S_IDLE;
        else begin
          st_d   = S_REQ;
          node_d = link_al;
          idx_d  = '0;
        end
      end
      S_RUN: if (mv_done_i) begin
        if (link_end) st_d = S_IDLE;
        else begin
          st_d   = S_REQ;
          node_d = link_al;
          idx_d  = '0;
        end
      end
      default: st_d = S_IDLE;
    endcase

    if (cancel_i) st_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      node_q  <= '0;
      idx_q   <= '0;
      first_q <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      node_q  <= node_d;
      idx_q   <= idx_d;
      first_q <= first_d;
      stale_q <= stale_d;
    end
  end

  logic unused_link;
  assign unused_link = ^{link_i[ALIGN-1:0]};

  assert_addr_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o |-> (rd_addr_o[ALIGN-1:0] == '0));

  assert_req_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_gnt_i && !cancel_i) |=> (rd_req_o && $stable(rd_addr_o)));

  assert_cancel_to_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !busy_o);

  assert_idle_needs_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> !busy_o);

  assert_stale_no_capture_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cancel_i && rd_req_o && rd_gnt_i) |=> (!cap_o && !rd_req_o));

  assert_start_one_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_start_o |=> !mv_start_o);
endmodule

// File: rtl/llist_fetch.sv
module llist_fetch
  import llist_pkg::*;
#(
  parameter int         AW       = 32,
  parameter int         DW       = 32,
  parameter int         LEN_W    = 24,
  parameter int         WIN_AW   = 6,
  parameter logic [5:0] OFS_LIST = 6'h14,
  parameter logic [5:0] OFS_CTRL = 6'h1C,
  parameter int         BIT_EN   = 0,
  parameter int         BIT_LEN  = 4,
  parameter int         BIT_CAN  = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [WIN_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic              rd_req_o,
  output logic [AW-1:0]     rd_addr_o,
  input  logic              rd_gnt_i,
  input  logic              rd_rvalid_i,
  input  logic [DW-1:0]     rd_rdata_i,
  output logic              mv_start_o,
  output logic              mv_abort_o,
  input  logic              mv_done_i,
  output logic [DW-1:0]     cfg_gen_o,
  output logic [DW-1:0]     cfg_port_o,
  output logic [AW-1:0]     cfg_src_o,
  output logic [AW-1:0]     cfg_dst_o,
  output logic [LEN_W-1:0]  cfg_len_o,
  output logic              list_loaded_o,
  output logic              cmd_done_o,
  output logic              busy_o
);
  localparam int ALIGN = $clog2(DW / 8);

  logic [AW-1:0]                  list_addr;
  logic                           start, cancel, cap;
  logic [IDX_W-1:0]               idx;
  logic [NODE_WORDS-1:0][DW-1:0]  words;

  llist_ctrl_regs #(
    .AW(AW), .DW(DW), .WIN_AW(WIN_AW), .ALIGN(ALIGN),
    .OFS_LIST(OFS_LIST), .OFS_CTRL(OFS_CTRL),
    .BIT_EN(BIT_EN), .BIT_LEN(BIT_LEN), .BIT_CAN(BIT_CAN)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .list_addr_o (list_addr),
    .start_o     (start),
    .cancel_o    (cancel)
  );

  llist_node_buf #(.DW(DW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_i   (cap),
    .idx_i   (idx),
    .data_i  (rd_rdata_i),
    .words_o (words)
  );

  llist_seq #(.AW(AW), .ALIGN(ALIGN)) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start),
    .cancel_i      (cancel),
    .list_addr_i   (list_addr),
    .link_i        (words[W_LINK][AW-1:0]),
    .run_en_i      (words[W_CTRL][BIT_EN]),
    .rd_gnt_i      (rd_gnt_i),
    .rd_rvalid_i   (rd_rvalid_i),
    .mv_done_i     (mv_done_i),
    .rd_req_o      (rd_req_o),
    .rd_addr_o     (rd_addr_o),
    .cap_o         (cap),
    .idx_o         (idx),
    .mv_start_o    (mv_start_o),
    .mv_abort_o    (mv_abort_o),
    .list_loaded_o (list_loaded_o),
    .cmd_done_o    (cmd_done_o),
    .busy_o        (busy_o)
  );

  assign cfg_gen_o  = words[W_GEN];
  assign cfg_port_o = words[W_PORT];
  assign cfg_src_o  = words[W_SRC][AW-1:0];
  assign cfg_dst_o  = words[W_DST][AW-1:0];
  assign cfg_len_o  = words[W_LEN][LEN_W-1:0];

  logic unused_words;
  assign unused_words = ^{words[W_CDONE], words[W_LEN][DW-1:LEN_W], words[W_CTRL]};

  assert_loaded_with_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    list_loaded_o |-> (busy_o && !rd_req_o && !cmd_done_o));

  assert_done_ignored_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o) |-> !cmd_done_o);
endmodule

// File: tb/llist_fetch_bench.sv
`timescale 1ns/1ps
module llist_fetch_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [5:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic        rd_req_o;
  logic [31:0] rd_addr_o;
  logic        rd_gnt_i = 0;
  logic        rd_rvalid_i = 0;
  logic [31:0] rd_rdata_i = 0;
  logic        mv_start_o, mv_abort_o;
  logic        mv_done_i = 0;
  logic [31:0] cfg_gen_o, cfg_port_o, cfg_src_o, cfg_dst_o;
  logic [23:0] cfg_len_o;
  logic        list_loaded_o, cmd_done_o, busy_o;

  always #10 clk = ~clk;

  llist_fetch u_llist_fetch (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_gnt_i(rd_gnt_i),
    .rd_rvalid_i(rd_rvalid_i), .rd_rdata_i(rd_rdata_i),
    .mv_start_o(mv_start_o), .mv_abort_o(mv_abort_o), .mv_done_i(mv_done_i),
    .cfg_gen_o(cfg_gen_o), .cfg_port_o(cfg_port_o), .cfg_src_o(cfg_src_o),
    .cfg_dst_o(cfg_dst_o), .cfg_len_o(cfg_len_o),
    .list_loaded_o(list_loaded_o), .cmd_done_o(cmd_done_o), .busy_o(busy_o)
  );

  int checks = 0, errors = 0, cyc = 0;
  int rd_lat = 1, mv_dly = 3, done_due = -1;
  bit gnt_alt = 0, force_done = 0;
  int acc_cnt = 0, start_cnt = 0, done_cnt = 0, load_cnt = 0, abort_cnt = 0;
  logic [31:0] last_gen, last_port, last_src, last_dst;
  logic [23:0] last_len;
  logic [31:0] mem [int];
  int   rq_due [$];
  logic [31:0] rq_addr [$];

  // reference model state
  int m_ph, m_ix;
  logic [31:0] m_nd, m_lreg, lk;
  logic [31:0] m_w [8];
  bit m_first, m_stale, mc, ms, mreq, nst;
  bit e_c, e_req, e_load, e_start, e_done, e_abort, e_busy;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic put_node(input int base, input logic [31:0] gen, port, src, dst, len, link, ctrl);
    mem[base] = gen; mem[base+4] = port; mem[base+8] = src; mem[base+12] = dst;
    mem[base+16] = len; mem[base+20] = link; mem[base+24] = 32'h0; mem[base+28] = ctrl;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0; reg_wdata = 0;
    #2;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #2; end
  endtask

  task automatic wait_idle();
    int t = 0;
    step(1);
    while (busy_o && t < 3000) begin step(1); t++; end
  endtask

  task automatic pulse_done();
    force_done = 1; step(1); force_done = 0;
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory and data mover stand-ins
  always @(negedge clk) begin
    rd_gnt_i = gnt_alt ? cyc[0] : 1'b1;
    rd_rvalid_i = 0;
    if (rq_due.size() > 0 && rq_due[0] <= cyc) begin
      rd_rvalid_i = 1;
      rd_rdata_i = mem.exists(int'(rq_addr[0])) ? mem[int'(rq_addr[0])] : (32'hDEAD_0000 | rq_addr[0]);
      void'(rq_due.pop_front());
      void'(rq_addr.pop_front());
    end
    mv_done_i = force_done || (done_due == cyc);
    if (done_due == cyc) done_due = -1;
  end

  // reference model, advanced at each clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_ix = 0; m_nd = 0; m_lreg = 0; m_first = 0; m_stale = 0;
      for (int i = 0; i < 8; i++) m_w[i] = 0;
    end else begin
      mc   = reg_we && reg_addr == 6'h1C && reg_wdata[20];
      ms   = reg_we && reg_addr == 6'h1C && reg_wdata[4] && reg_wdata[0] && !reg_wdata[20];
      mreq = (m_ph == 1) && !m_stale;
      nst  = m_stale && !rd_rvalid_i;
      if (mc) nst = nst || (m_ph == 2 && !rd_rvalid_i) || (mreq && rd_gnt_i);
      lk = m_w[5] & ~32'h3;
      if (mc && m_ph != 0) m_ph = 0;
      else if (m_ph == 0) begin
        if (ms) begin m_ph = 1; m_nd = m_lreg & ~32'h3; m_ix = 0; m_first = 1; end
      end else if (m_ph == 1) begin
        if (mreq && rd_gnt_i) m_ph = 2;
      end else if (m_ph == 2) begin
        if (rd_rvalid_i) begin
          m_w[m_ix] = rd_rdata_i;
          if (m_ix == 7) m_ph = 3; else begin m_ix++; m_ph = 1; end
        end
      end else if (m_ph == 3) begin
        m_first = 0;
        if (m_w[7][0]) m_ph = 4;
        else if (lk == 0) m_ph = 0;
        else begin m_nd = lk; m_ix = 0; m_ph = 1; end
      end else if (m_ph == 4) begin
        if (mv_done_i) begin
          if (lk == 0) m_ph = 0;
          else begin m_nd = lk; m_ix = 0; m_ph = 1; end
        end
      end
      m_stale = nst;
      if (reg_we && reg_addr == 6'h14) m_lreg = reg_wdata;
    end
  end

  // per-cycle comparison and event bookkeeping
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      e_c     = reg_we && reg_addr == 6'h1C && reg_wdata[20];
      e_req   = (m_ph == 1) && !m_stale;
      e_load  = (m_ph == 3) && m_first && !e_c;
      e_start = (m_ph == 3) && m_w[7][0] && !e_c;
      e_done  = (m_ph == 4) && mv_done_i && !e_c;
      e_abort = (m_ph == 4) && e_c;
      e_busy  = (m_ph != 0);
      check(rd_req_o == e_req, "R3 rd_req_o", rd_req_o, e_req);
      if (e_req) check(rd_addr_o == m_nd + 4 * m_ix, "R3 rd_addr_o", rd_addr_o, m_nd + 4 * m_ix);
      check(list_loaded_o == e_load, "R5 list_loaded_o", list_loaded_o, e_load);
      check(mv_start_o == e_start, "R6 mv_start_o", mv_start_o, e_start);
      check(cmd_done_o == e_done, "R7 cmd_done_o", cmd_done_o, e_done);
      check(mv_abort_o == e_abort, "R9 mv_abort_o", mv_abort_o, e_abort);
      check(busy_o == e_busy, "R11 busy_o", busy_o, e_busy);
      if (rd_req_o && rd_gnt_i) begin
        rq_due.push_back(cyc + rd_lat); rq_addr.push_back(rd_addr_o); acc_cnt++;
      end
      if (mv_start_o) begin
        done_due = cyc + mv_dly; start_cnt++;
        last_gen = cfg_gen_o; last_port = cfg_port_o; last_src = cfg_src_o;
        last_dst = cfg_dst_o; last_len = cfg_len_o;
      end
      if (mv_abort_o) begin done_due = -1; abort_cnt++; end
      if (cmd_done_o) done_cnt++;
      if (list_loaded_o) load_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0, s0, d0, l0, b0, t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(1);
    // R1
    check(!busy_o && !rd_req_o && !mv_start_o && !cmd_done_o && !list_loaded_o && !mv_abort_o,
          "R1 reset idle", {26'b0, busy_o, rd_req_o, mv_start_o, cmd_done_o, list_loaded_o, mv_abort_o}, 0);

    put_node(32'h100, 32'hA0A0_0001, 32'h0000_0120, 32'h0000_1000, 32'h0000_2000,
             32'h5500_003F, 32'h0, 32'h11);
    // R2: partial control writes do not start
    wr(6'h14, 32'h100);
    wr(6'h1C, 32'h10);
    wr(6'h1C, 32'h01);
    step(5);
    check(!busy_o && acc_cnt == 0, "R2 partial enable ignored", acc_cnt, 0);

    // single node
    a0 = acc_cnt;
    wr(6'h1C, 32'h11);
    wait_idle();
    check(acc_cnt - a0 == 8, "R3 eight reads per node", acc_cnt - a0, 8);
    check(last_gen == 32'hA0A0_0001, "R4 cfg_gen_o", last_gen, 32'hA0A0_0001);
    check(last_port == 32'h0000_0120, "R4 cfg_port_o", last_port, 32'h120);
    check(last_src == 32'h1000 && last_dst == 32'h2000, "R4 cfg_src_o/cfg_dst_o", last_src, 32'h1000);
    check(last_len == 24'h00003F, "R4 cfg_len_o low 24 bits", {8'h0, last_len}, 32'h3F);
    check(done_cnt == 1 && load_cnt == 1, "R7 single completion", done_cnt, 1);

    // chain with stalls, unaligned link, disabled middle node
    put_node(32'h200, 32'hB, 32'h1, 32'h3000, 32'h4000, 32'h7, 32'h302, 32'h11);
    put_node(32'h300, 32'hC, 32'h1, 32'h3100, 32'h4100, 32'h7, 32'h400, 32'h10);
    put_node(32'h400, 32'hD, 32'h1, 32'h3200, 32'h4200, 32'h7, 32'h0, 32'h11);
    gnt_alt = 1; rd_lat = 3; mv_dly = 5;
    a0 = acc_cnt; s0 = start_cnt; d0 = done_cnt; l0 = load_cnt;
    wr(6'h14, 32'h200);
    wr(6'h1C, 32'h11);
    t = 0;
    while (start_cnt == s0 && t < 2000) begin step(1); t++; end
    wr(6'h14, 32'h100);
    wr(6'h1C, 32'h11);           // R2: start while busy has no effect
    wait_idle();
    check(acc_cnt - a0 == 24, "R3 reads over three nodes", acc_cnt - a0, 24);
    check(start_cnt - s0 == 2, "R6 disabled node skipped", start_cnt - s0, 2);
    check(done_cnt - d0 == 2, "R7 completions in chain", done_cnt - d0, 2);
    check(load_cnt - l0 == 1, "R5 one loaded event per chain", load_cnt - l0, 1);
    check(last_gen == 32'hD, "R2 busy start ignored, chain kept", last_gen, 32'hD);

    // circular chain, cancelled while running
    put_node(32'h500, 32'hE, 32'h1, 32'h5000, 32'h6000, 32'h3, 32'h540, 32'h11);
    put_node(32'h540, 32'hF, 32'h1, 32'h5100, 32'h6100, 32'h3, 32'h500, 32'h11);
    gnt_alt = 0; rd_lat = 1; mv_dly = 6;
    d0 = done_cnt; l0 = load_cnt; b0 = abort_cnt;
    wr(6'h14, 32'h500);
    wr(6'h1C, 32'h11);
    t = 0;
    while (done_cnt - d0 < 5 && t < 5000) begin step(1); t++; end
    s0 = start_cnt;
    while (start_cnt == s0 && t < 5000) begin step(1); t++; end
    wr(6'h1C, 32'h0010_0011);     // cancel wins over list enable
    step(10);
    check(!busy_o, "R9 cancel returns idle", busy_o, 0);
    check(abort_cnt - b0 == 1, "R9 abort pulse", abort_cnt - b0, 1);
    check(done_cnt - d0 == 5, "R8 circular completions", done_cnt - d0, 5);
    check(load_cnt - l0 == 1, "R5 loaded once in circular chain", load_cnt - l0, 1);

    // cancel with a read in flight, then restart at once
    put_node(32'h600, 32'h6666, 32'h1, 32'h0, 32'h0, 32'h1, 32'h0, 32'h11);
    put_node(32'h700, 32'h7777, 32'h1, 32'h0, 32'h0, 32'h1, 32'h0, 32'h11);
    rd_lat = 6; mv_dly = 2;
    wr(6'h14, 32'h600);
    a0 = acc_cnt;
    wr(6'h1C, 32'h11);
    t = 0;
    while (acc_cnt == a0 && t < 200) begin step(1); t++; end
    wr(6'h1C, 32'h0010_0000);
    wr(6'h14, 32'h700);
    wr(6'h1C, 32'h11);
    wait_idle();
    check(last_gen == 32'h7777, "R10 stale response dropped", last_gen, 32'h7777);
    check(acc_cnt - a0 == 9, "R10 reads issued", acc_cnt - a0, 9);

    // stray done pulses
    rd_lat = 1; mv_dly = 4;
    d0 = done_cnt;
    pulse_done();
    step(2);
    check(!busy_o && done_cnt == d0, "R12 done while idle ignored", done_cnt - d0, 0);
    wr(6'h14, 32'h100);
    a0 = acc_cnt;
    wr(6'h1C, 32'h11);
    t = 0;
    while (acc_cnt - a0 < 2 && t < 200) begin step(1); t++; end
    pulse_done();
    wait_idle();
    check(done_cnt - d0 == 1, "R12 done while fetching ignored", done_cnt - d0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule